// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 32-bit load/store core fetches next. It covers conditional branches on equality and inequality, and jumps to an immediate target. It takes five inputs: the instruction word being executed, its sign-extended immediate, that instruction's PC, the equality flag from the ALU, and a 2-bit flow selector from the decoder. It returns the next program counter and a single flag that says control flow is being redirected.

A conditional branch lands at the address after the branch plus the immediate counted in words. An immediate jump keeps the top four bits of the branch's own PC and fills the rest from the 26-bit target field, scaled to a word address. The fetch stage uses the redirect flag to turn the instruction it has already fetched into an all-zero word, which behaves as a no-operation. The flag therefore rises only for a taken branch or a jump. The unit is purely combinational.

Top module: `bju_next_pc`

## Requirements
- R1: With flow selector 0 (no flow change), next_pc is cur_pc + 4 and redirect is 0, whatever alu_zero, imm_ext and insn_word hold.
- R2: With flow selector 1 (branch on equal) and alu_zero = 1, redirect is 1 and next_pc is cur_pc + 4 + (imm_ext << 2).
- R3: With flow selector 1 and alu_zero = 0, redirect is 0 and next_pc is cur_pc + 4.
- R4: With flow selector 2 (branch on not equal) and alu_zero = 0, redirect is 1 and next_pc is cur_pc + 4 + (imm_ext << 2).
- R5: With flow selector 2 and alu_zero = 1, redirect is 0 and next_pc is cur_pc + 4.
- R6: With flow selector 3 (immediate jump), redirect is 1 and next_pc is (cur_pc & 0xF0000000) | (insn_word[25:0] << 2), whatever alu_zero holds.
- R7: For a jump, insn_word[31:26] and imm_ext have no effect on next_pc.
- R8: Branch target arithmetic is modulo 2^32: negative immediates move the target backwards, results wrap through zero, and imm_ext[31:30] are dropped by the word scaling.
- R9: The jump keeps the top four bits of cur_pc itself, not of cur_pc + 4, so a jump in the last word of a 256 MiB region stays in that region.
- R10: For a branch, insn_word has no effect on next_pc or redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 32 | Instruction being executed; bits 25:0 hold the jump target field |
| imm_ext | input | 32 | Sign-extended branch immediate, in words |
| cur_pc | input | 32 | PC of the instruction being executed |
| alu_zero | input | 1 | 1 when the two compared registers are equal |
| flow_sel | input | 2 | 0 none, 1 branch on equal, 2 branch on not equal, 3 immediate jump |
| next_pc | output | 32 | Address to fetch next |
| redirect | output | 1 | 1 when control flow changes; the fetch stage squashes the fetched word to zero |

## Verification
The bench puts a jump in the last word of a 256 MiB region. A design that took the region bits from the incremented PC would land one region too high. Backward branches and branches whose target wraps through address zero are run to catch a missing sign extension or a wrong scaling shift. Both polarities of the zero flag are applied under each branch kind, so a swapped condition shows up as a redirect raised on a branch that should fall through, which would squash a valid instruction. Jumps carry opcode bits, an immediate and a zero flag that are all meant to be ignored. A design that let any of them leak would produce a wrong target or a missing redirect.

// File: rtl/bju_pkg.sv
package bju_pkg;

    localparam int XLEN_DFLT   = 32;
    localparam int REGION_DFLT = 4;
    localparam int ALIGN_DFLT  = 2;

    typedef enum logic [1:0] {
        FLOW_NONE = 2'd0,
        FLOW_BEQ  = 2'd1,
        FLOW_BNE  = 2'd2,
        FLOW_JUMP = 2'd3
    } flow_e;

    typedef struct packed {
        logic taken;
        logic use_jump;
    } flow_dec_t;

    function automatic flow_dec_t decode_flow(input flow_e sel, input logic eq);
        flow_dec_t d;
        d = '0;
        unique case (sel)
            FLOW_BEQ:  d.taken = eq;
            FLOW_BNE:  d.taken = ~eq;
            FLOW_JUMP: begin
                d.taken    = 1'b1;
                d.use_jump = 1'b1;
            end
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bju_seq_adder.sv
module bju_seq_adder #(
    parameter int XLEN  = bju_pkg::XLEN_DFLT,
    parameter int ALIGN = bju_pkg::ALIGN_DFLT
) (
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] pc_seq
);
    localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

    assign pc_seq = pc_in + STEP;
endmodule

// File: rtl/bju_branch_target.sv
module bju_branch_target #(
    parameter int XLEN  = bju_pkg::XLEN_DFLT,
    parameter int ALIGN = bju_pkg::ALIGN_DFLT
) (
    input  logic [XLEN-1:0] pc_seq,
    input  logic [XLEN-1:0] imm_words,
    output logic [XLEN-1:0] br_target
);
    logic [XLEN-1:0] byte_off;

    generate
        if (ALIGN == 0) begin : g_noscale
            assign byte_off = imm_words;
        end else begin : g_scale
            assign byte_off = {imm_words[XLEN-1-ALIGN:0], {ALIGN{1'b0}}};
        end
    endgenerate

    assign br_target = pc_seq + byte_off;
endmodule

// File: rtl/bju_jump_target.sv
module bju_jump_target #(
    parameter int XLEN     = bju_pkg::XLEN_DFLT,
    parameter int REGION_W = bju_pkg::REGION_DFLT,
    parameter int ALIGN    = bju_pkg::ALIGN_DFLT
) (
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] insn,
    output logic [XLEN-1:0] jmp_target
);
    localparam int FIELD_W = XLEN - REGION_W - ALIGN;

    logic [XLEN-1:0] body;

    generate
        if (ALIGN == 0) begin : g_noalign
            assign body = XLEN'(insn[FIELD_W-1:0]);
        end else begin : g_align
            assign body = XLEN'({insn[FIELD_W-1:0], {ALIGN{1'b0}}});
        end

        if (REGION_W == 0) begin : g_flat
            assign jmp_target = body;
        end else begin : g_region
            assign jmp_target = {pc_in[XLEN-1 -: REGION_W], body[XLEN-REGION_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/bju_flow_ctl.sv
module bju_flow_ctl
    import bju_pkg::*;
(
    input  logic [1:0] sel_raw,
    input  logic       eq_flag,
    output logic       take,
    output logic       pick_jump
);
    flow_e     sel;
    flow_dec_t dec;

    always_comb begin
        sel       = flow_e'(sel_raw);
        dec       = decode_flow(sel, eq_flag);
        take      = dec.taken;
        pick_jump = dec.use_jump;
    end
endmodule

// File: rtl/bju_next_pc.sv
module bju_next_pc #(
    parameter int XLEN     = bju_pkg::XLEN_DFLT,
    parameter int REGION_W = bju_pkg::REGION_DFLT,
    parameter int ALIGN    = bju_pkg::ALIGN_DFLT
) (
    input  logic [XLEN-1:0] insn_word,
    input  logic [XLEN-1:0] imm_ext,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            alu_zero,
    input  logic [1:0]      flow_sel,
    output logic [XLEN-1:0] next_pc,
    output logic            redirect
);
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic            take;
    logic            pick_jump;

    bju_seq_adder #(.XLEN(XLEN), .ALIGN(ALIGN)) u_seq (
        .pc_in  (cur_pc),
        .pc_seq (pc_seq)
    );

    bju_branch_target #(.XLEN(XLEN), .ALIGN(ALIGN)) u_br (
        .pc_seq    (pc_seq),
        .imm_words (imm_ext),
        .br_target (br_target)
    );

    bju_jump_target #(.XLEN(XLEN), .REGION_W(REGION_W), .ALIGN(ALIGN)) u_jmp (
        .pc_in      (cur_pc),
        .insn       (insn_word),
        .jmp_target (jmp_target)
    );

    bju_flow_ctl u_ctl (
        .sel_raw   (flow_sel),
        .eq_flag   (alu_zero),
        .take      (take),
        .pick_jump (pick_jump)
    );

    always_comb begin
        if (pick_jump)
            next_pc = jmp_target;
        else if (take)
            next_pc = br_target;
        else
            next_pc = pc_seq;
        redirect = take;
    end
endmodule

// File: rtl/bju_next_pc_chk.sv
module bju_next_pc_chk #(
    parameter int XLEN     = bju_pkg::XLEN_DFLT,
    parameter int REGION_W = bju_pkg::REGION_DFLT,
    parameter int ALIGN    = bju_pkg::ALIGN_DFLT
) (
    input logic [XLEN-1:0] insn_word,
    input logic [XLEN-1:0] imm_ext,
    input logic [XLEN-1:0] cur_pc,
    input logic            alu_zero,
    input logic [1:0]      flow_sel,
    input logic [XLEN-1:0] next_pc,
    input logic            redirect
);
    logic known;

    always_comb begin
        known = !$isunknown({cur_pc, alu_zero, flow_sel, next_pc, redirect});
        if (known) begin
            // R1
            a_r1_idle_seq: assert (flow_sel != 2'd0 || (!redirect && next_pc == cur_pc + XLEN'(4)))
                else $error("R1 idle selector changed flow");
            // R3 R5
            a_r3_r5_fallthrough: assert (redirect || next_pc == cur_pc + XLEN'(4))
                else $error("R3/R5 no redirect yet next_pc not sequential");
            // R2 R4
            a_r2_r4_condition: assert (!(flow_sel == 2'd1 || flow_sel == 2'd2)
                                       || redirect == (flow_sel == 2'd1 ? alu_zero : !alu_zero))
                else $error("R2/R4 branch condition polarity wrong");
            // R6 R9
            a_r6_jump_region: assert (flow_sel != 2'd3
                                      || (redirect && next_pc[XLEN-1 -: REGION_W] == cur_pc[XLEN-1 -: REGION_W]
                                          && next_pc[ALIGN-1:0] == '0))
                else $error("R6/R9 jump left its region or missed redirect");
        end
    end
endmodule

bind bju_next_pc bju_next_pc_chk #(.XLEN(XLEN), .REGION_W(REGION_W), .ALIGN(ALIGN)) u_chk (
    .insn_word (insn_word),
    .imm_ext   (imm_ext),
    .cur_pc    (cur_pc),
    .alu_zero  (alu_zero),
    .flow_sel  (flow_sel),
    .next_pc   (next_pc),
    .redirect  (redirect)
);

// File: tb/bju_next_pc_bench.sv
module bju_next_pc_bench;
    logic        clk = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] imm_ext   = '0;
    logic [31:0] cur_pc    = '0;
    logic        alu_zero  = 1'b0;
    logic [1:0]  flow_sel  = 2'd0;
    logic [31:0] next_pc;
    logic        redirect;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bju_next_pc u_bju_next_pc (
        .insn_word (insn_word),
        .imm_ext   (imm_ext),
        .cur_pc    (cur_pc),
        .alu_zero  (alu_zero),
        .flow_sel  (flow_sel),
        .next_pc   (next_pc),
        .redirect  (redirect)
    );

    task automatic drive(input logic [1:0] s, input logic z, input logic [31:0] pc,
                         input logic [31:0] imm, input logic [31:0] insn);
        @(negedge clk);
        flow_sel  = s;
        alu_zero  = z;
        cur_pc    = pc;
        imm_ext   = imm;
        insn_word = insn;
        #1;
    endtask

    task automatic expect_out(input string req, input logic [31:0] exp_pc, input logic exp_tk);
        checks++;
        if (next_pc !== exp_pc) begin
            errors++;
            $display("FAIL %s next_pc actual=%08h expected=%08h", req, next_pc, exp_pc);
        end
        checks++;
        if (redirect !== exp_tk) begin
            errors++;
            $display("FAIL %s redirect actual=%0b expected=%0b", req, redirect, exp_tk);
        end
    endtask

    task automatic t_r1_idle();
        drive(2'd0, 1'b0, 32'h0040_0000, 32'h0000_0010, 32'h0800_0123);
        expect_out("R1", 32'h0040_0004, 1'b0);
        drive(2'd0, 1'b1, 32'h0040_0000, 32'hFFFF_FFFF, 32'h0C00_0456);
        expect_out("R1", 32'h0040_0004, 1'b0);
    endtask

    task automatic t_r2_r3_beq();
        drive(2'd1, 1'b1, 32'h0040_0010, 32'd5, 32'h1109_0005);
        expect_out("R2", 32'h0040_0028, 1'b1);
        drive(2'd1, 1'b0, 32'h0040_0010, 32'd5, 32'h1109_0005);
        expect_out("R3", 32'h0040_0014, 1'b0);
    endtask

    task automatic t_r4_r5_bne();
        drive(2'd2, 1'b0, 32'h0040_0100, 32'hFFFF_FFFD, 32'h1509_FFFD);
        expect_out("R4", 32'h0040_00F8, 1'b1);
        drive(2'd2, 1'b1, 32'h0040_0100, 32'hFFFF_FFFD, 32'h1509_FFFD);
        expect_out("R5", 32'h0040_0104, 1'b0);
    endtask

    task automatic t_r6_r7_jump();
        drive(2'd3, 1'b0, 32'h8000_1000, 32'h0000_0000, 32'h0800_0040);
        expect_out("R6", 32'h8000_0100, 1'b1);
        drive(2'd3, 1'b1, 32'h8000_1000, 32'h1234_5678, 32'h0C00_0040);
        expect_out("R6", 32'h8000_0100, 1'b1);
        drive(2'd3, 1'b0, 32'h8000_1000, 32'hFFFF_FFFF, 32'hFC00_0040);
        expect_out("R7", 32'h8000_0100, 1'b1);
        drive(2'd3, 1'b1, 32'hA123_4560, 32'h0, 32'h0BFF_FFFF);
        expect_out("R6", 32'hAFFF_FFFC, 1'b1);
    endtask

    task automatic t_r9_region_edge();
        drive(2'd3, 1'b0, 32'h0FFF_FFFC, 32'h0, 32'h0800_0004);
        expect_out("R9", 32'h0000_0010, 1'b1);
        drive(2'd3, 1'b0, 32'h0FFF_FFFC, 32'h0, 32'h0BFF_FFFF);
        expect_out("R9", 32'h0FFF_FFFC, 1'b1);
    endtask

    task automatic t_r8_wrap();
        drive(2'd1, 1'b1, 32'hFFFF_FFF8, 32'd2, 32'h1000_0002);
        expect_out("R8", 32'h0000_0004, 1'b1);
        drive(2'd2, 1'b0, 32'h0000_0004, 32'hFFFF_FFFC, 32'h1400_FFFC);
        expect_out("R8", 32'hFFFF_FFF8, 1'b1);
        drive(2'd1, 1'b1, 32'h0000_0100, 32'h4000_0001, 32'h1000_0001);
        expect_out("R8", 32'h0000_0108, 1'b1);
    endtask

    task automatic t_r10_insn_ignored();
        drive(2'd1, 1'b1, 32'h0040_0010, 32'd5, 32'hFFFF_FFFF);
        expect_out("R10", 32'h0040_0028, 1'b1);
        drive(2'd2, 1'b1, 32'h0040_0010, 32'd5, 32'h0800_0000);
        expect_out("R10", 32'h0040_0014, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        expect_out("R1", 32'h0000_0004, 1'b0);
        t_r1_idle();
        t_r2_r3_beq();
        t_r4_r5_bne();
        t_r6_r7_jump();
        t_r9_region_edge();
        t_r8_wrap();
        t_r10_insn_ignored();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule